// File: doc/BRIEF.md
# Pixel Sample Pulse Timing Generator

This block turns a master clock and a once-per-pixel timing strobe into two internal sampling pulses for a correlated double sampling front end. One is a data-level pulse, called SHD here, whose falling edge is the data sampling instant. The other is a reference-level pulse, called SHR here, which samples the feed-through level and also closes the clamp switch while it is high. The master clock runs at eight times the pixel rate, so one pixel lasts eight rising edges. All timing is counted on rising edges.

The strobe may stay high for one to three rising edges. The last edge that sees it high is the timing reference. SHD falls on the next edge, which is the first edge that sees the strobe low again. SHD can be built from the clock, with a programmable width that stretches backward from a fixed falling edge, or it can follow the strobe directly. SHR lasts one clock period and falls a programmable number of periods after the SHD falling edge. SHR runs only in CDS input mode. Both pulses are held low while the block is powered down. A strobe that stays high for a fourth edge raises a one-cycle error pulse and drops the timing lock.

A three-state sequencer handles lock. OFF: powered down, everything cleared. It goes to HUNT when power is applied. HUNT: waiting for the first strobe falling edge. It goes to TRACK on that edge, or back to OFF on power-down. TRACK: a phase counter follows the pixel period, and the pulses are generated ahead of the next predicted reference. It goes to HUNT on an overlong strobe, or to OFF on power-down.

Top module: `sample_pulse_gen`

## Requirements
- R1: After reset, `shd`, `shr` and `strobe_err` are all 0.
- R2: With `shd_from_strobe`=0, `shd` goes low at the first rising edge that sees `strobe` low after it was high. It has already been high for `shd_width`+1 clock periods before that edge (code 00 gives 1 period, 11 gives 4). Changing the code moves only the rising edge.
- R3: The SHD and SHR timing depends only on the last edge that sees the strobe high. A strobe that is high for 1, 2 or 3 edges, ending on the same edge, gives identical pulses.
- R4: With `shd_from_strobe`=1, `shd` equals `strobe` whenever `pwr_on`=1, and `shd_width` has no effect.
- R5: With `cds_mode`=1, `shr` is high for exactly one clock period. It falls `shr_delay`+2 rising edges after the SHD falling edge (code 00 gives 2, 11 gives 5). In other words, it is high after edge `shr_delay`+1, counted from the reference-fall edge.
- R6: With `cds_mode`=0, `shr` stays low.
- R7: With `pwr_on`=0, `shd` and `shr` are low in both SHD sources, and all timing state is cleared. After power returns, no clock-built SHD and no SHR appear until a strobe falling edge has been seen.
- R8: `strobe_err` is high for exactly one cycle, in the cycle after the fourth consecutive rising edge that sees the strobe high. It does not pulse again while the strobe stays high.
- R9: On the fourth consecutive high edge, a clock-built SHD that is in progress is cut off, and pulses stay stopped until the next strobe falling edge. Normal timing then resumes from that falling edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock, 8x pixel rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on | input | 1 | 1 = operating, 0 = powered down |
| strobe | input | 1 | Pixel timing strobe |
| cds_mode | input | 1 | 1 = CDS input mode, 0 = direct-coupled |
| shd_from_strobe | input | 1 | 1 = SHD follows the strobe, 0 = SHD built from the clock |
| shd_width | input | 2 | SHD high time code (periods minus one) |
| shr_delay | input | 2 | SHR falling-edge delay code (periods minus two) |
| shd | output | 1 | Data-level sample pulse |
| shr | output | 1 | Reference-level sample pulse, also the clamp switch enable |
| strobe_err | output | 1 | One-cycle flag for an overlong strobe |

## Verification
The hardest case to reach is an overlong strobe that arrives while the block is already locked. A clock-built SHD pulse must be in progress, so the strobe has to stay high past its third edge while SHD is already high. The stimulus first locks the block with normal pixels and selects the widest SHD code. It then sends one pixel whose strobe covers five edges. The bench checks that SHD is cut on the fourth edge and that the error pulse lasts one cycle. It then checks that the next ordinary pixel relocks with full timing. A second hard case is the first pixel after power returns: the bench checks that the block waits for a strobe fall before producing any clock-built pulse.

// File: rtl/sp_pkg.sv
`timescale 1ns/1ps
package sp_pkg;

    // Lock sequencer states
    typedef enum logic [1:0] {
        SEQ_OFF   = 2'd0,
        SEQ_HUNT  = 2'd1,
        SEQ_TRACK = 2'd2
    } seq_state_t;

    // Longest legal strobe, in rising edges
    localparam int STROBE_MAX_HI = 3;

endpackage

// File: rtl/sp_strobe_mon.sv
`timescale 1ns/1ps
// Watches the pixel strobe: reference-fall detection and overlong detection
module sp_strobe_mon #(
    parameter int MAX_HI = 3,
    localparam int CW    = $clog2(MAX_HI + 2)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic strobe,
    output logic fall_evt,
    output logic over_now,
    output logic err_q
);

    logic          strobe_q;
    logic [CW-1:0] hi_cnt;

    // Edge after the last high edge: the SHD falling reference
    always_comb begin
        fall_evt = run && strobe_q && !strobe;
        over_now = run && strobe && (hi_cnt == CW'(MAX_HI));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_q <= 1'b0;
            hi_cnt   <= '0;
            err_q    <= 1'b0;
        end else if (!run) begin
            strobe_q <= 1'b0;
            hi_cnt   <= '0;
            err_q    <= 1'b0;
        end else begin
            strobe_q <= strobe;
            err_q    <= over_now;
            if (!strobe)
                hi_cnt <= '0;
            else if (hi_cnt != CW'(MAX_HI + 1))
                hi_cnt <= hi_cnt + CW'(1);
        end
    end

endmodule

// File: rtl/sp_seq.sv
`timescale 1ns/1ps
// Lock sequencer and pixel phase counter
module sp_seq
    import sp_pkg::*;
#(
    parameter int PERIOD = 8,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          pwr_on,
    input  logic          fall_evt,
    input  logic          over_now,
    output logic          track,
    output logic [PW-1:0] phase
);

    seq_state_t state, state_n;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= SEQ_OFF;
        else
            state <= state_n;
    end

    // Next state
    always_comb begin
        state_n = state;
        unique case (state)
            SEQ_OFF:   state_n = pwr_on ? SEQ_HUNT : SEQ_OFF;
            SEQ_HUNT:  begin
                if (!pwr_on)       state_n = SEQ_OFF;
                else if (fall_evt) state_n = SEQ_TRACK;
            end
            SEQ_TRACK: begin
                if (!pwr_on)       state_n = SEQ_OFF;
                else if (over_now) state_n = SEQ_HUNT;
            end
            default:   state_n = SEQ_OFF;
        endcase
    end

    // Outputs
    always_comb begin
        track = (state == SEQ_TRACK);
    end

    // Phase within the pixel: 0 right after the reference-fall edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            phase <= '0;
        else if (state_n != SEQ_TRACK || fall_evt || phase == PW'(PERIOD - 1))
            phase <= '0;
        else
            phase <= phase + PW'(1);
    end

endmodule

// File: rtl/sp_pulse_gen.sv
`timescale 1ns/1ps
// Builds SHD and SHR from the pixel phase
module sp_pulse_gen #(
    parameter int PERIOD = 8,
    parameter int CODE_W = 2,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              track,
    input  logic              fall_evt,
    input  logic              over_now,
    input  logic [PW-1:0]     phase,
    input  logic              strobe,
    input  logic              cds_mode,
    input  logic              shd_from_strobe,
    input  logic [CODE_W-1:0] shd_width,
    input  logic [CODE_W-1:0] shr_delay,
    output logic              shd,
    output logic              shr
);

    logic          shd_q, shr_q, live;
    logic [PW-1:0] shd_start;

    always_comb begin
        live      = track && !over_now && !fall_evt;
        shd_start = PW'(PERIOD - 2) - PW'(shd_width);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shd_q <= 1'b0;
            shr_q <= 1'b0;
        end else begin
            if (!live || phase == PW'(PERIOD - 1))
                shd_q <= 1'b0;
            else if (phase == shd_start)
                shd_q <= 1'b1;
            shr_q <= live && (phase == PW'(shr_delay));
        end
    end

    always_comb begin
        shd = pwr_on && (shd_from_strobe ? strobe : shd_q);
        shr = pwr_on && cds_mode && shr_q;
    end

endmodule

// File: rtl/sample_pulse_gen.sv
`timescale 1ns/1ps
module sample_pulse_gen #(
    parameter int PERIOD = 8,
    parameter int CODE_W = 2,
    localparam int PW    = $clog2(PERIOD)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwr_on,
    input  logic              strobe,
    input  logic              cds_mode,
    input  logic              shd_from_strobe,
    input  logic [CODE_W-1:0] shd_width,
    input  logic [CODE_W-1:0] shr_delay,
    output logic              shd,
    output logic              shr,
    output logic              strobe_err
);

    logic          fall_evt, over_now, track;
    logic [PW-1:0] phase;

    sp_strobe_mon #(.MAX_HI(sp_pkg::STROBE_MAX_HI)) u_mon (
        .clk(clk), .rst_n(rst_n), .run(pwr_on), .strobe(strobe),
        .fall_evt(fall_evt), .over_now(over_now), .err_q(strobe_err)
    );

    sp_seq #(.PERIOD(PERIOD)) u_seq (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on),
        .fall_evt(fall_evt), .over_now(over_now),
        .track(track), .phase(phase)
    );

    sp_pulse_gen #(.PERIOD(PERIOD), .CODE_W(CODE_W)) u_gen (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .track(track),
        .fall_evt(fall_evt), .over_now(over_now), .phase(phase),
        .strobe(strobe), .cds_mode(cds_mode),
        .shd_from_strobe(shd_from_strobe), .shd_width(shd_width),
        .shr_delay(shr_delay), .shd(shd), .shr(shr)
    );

endmodule

// File: rtl/sample_pulse_gen_chk.sv
`timescale 1ns/1ps
module sample_pulse_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_on,
    input logic strobe,
    input logic cds_mode,
    input logic shd,
    input logic shr,
    input logic strobe_err
);

    assert_pd_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_on |-> (!shd && !shr));

    assert_dc_no_shr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !cds_mode |-> !shr);

    assert_shr_one_period_R5: assert property (@(posedge clk) disable iff (!rst_n)
        shr |=> !shr);

    assert_err_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |=> !strobe_err);

    assert_err_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        strobe_err |-> ($past(strobe, 1) && $past(strobe, 2) &&
                        $past(strobe, 3) && $past(strobe, 4)));

endmodule

bind sample_pulse_gen sample_pulse_gen_chk u_chk (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .strobe(strobe),
    .cds_mode(cds_mode), .shd(shd), .shr(shr), .strobe_err(strobe_err)
);

// File: tb/sample_pulse_gen_test.sv
`timescale 1ns/1ps
module sample_pulse_gen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwr_on = 1'b1;
    logic       strobe = 1'b0;
    logic       cds_mode = 1'b0;
    logic       shd_from_strobe = 1'b0;
    logic [1:0] shd_width = 2'd0;
    logic [1:0] shr_delay = 2'd0;
    logic       shd, shr, strobe_err;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;   // 250 MHz

    sample_pulse_gen uut (
        .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .strobe(strobe),
        .cds_mode(cds_mode), .shd_from_strobe(shd_from_strobe),
        .shd_width(shd_width), .shr_delay(shr_delay),
        .shd(shd), .shr(shr), .strobe_err(strobe_err)
    );

    // {from_strobe, cds, width[1:0], delay[1:0], high_edges[1:0]}
    localparam logic [7:0] VEC [12] = '{
        {1'b0, 1'b1, 2'd0, 2'd0, 2'd1},
        {1'b0, 1'b1, 2'd1, 2'd1, 2'd2},
        {1'b0, 1'b1, 2'd2, 2'd2, 2'd3},
        {1'b0, 1'b1, 2'd3, 2'd3, 2'd1},
        {1'b0, 1'b1, 2'd3, 2'd0, 2'd3},
        {1'b0, 1'b0, 2'd0, 2'd3, 2'd2},
        {1'b0, 1'b0, 2'd2, 2'd1, 2'd1},
        {1'b1, 1'b1, 2'd0, 2'd2, 2'd2},
        {1'b1, 1'b1, 2'd3, 2'd0, 2'd3},
        {1'b1, 1'b0, 2'd1, 2'd3, 2'd1},
        {1'b0, 1'b1, 2'd0, 2'd3, 2'd3},
        {1'b0, 1'b1, 2'd1, 2'd2, 2'd1}
    };

    task automatic chk(input string tag, input string what, input logic act, input logic exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", tag, what, act, exp, $time);
        end
    endtask

    // One pixel of 8 edges; strobe high for edges j in [hi_lo, hi_hi].
    // Sample after edge j compared with bit j of each mask.
    task automatic pixel(input int hi_lo, input int hi_hi, input bit do_chk,
                         input logic [7:0] shd_m, input logic [7:0] shr_m,
                         input logic [7:0] err_m,
                         input string t_shd, input string t_shr, input string t_err);
        for (int j = 0; j < 8; j++) begin
            strobe = (j >= hi_lo) && (j <= hi_hi);
            @(posedge clk);
            @(negedge clk);
            if (do_chk) begin
                chk(t_shd, "shd", shd, shd_m[j]);
                chk(t_shr, "shr", shr, shr_m[j]);
                chk(t_err, "strobe_err", strobe_err, err_m[j]);
            end
        end
    endtask

    function automatic logic [7:0] from_mask(input int lo);
        logic [7:0] m = '0;
        for (int j = 0; j < 8; j++) m[j] = (j >= lo);
        return m;
    endfunction

    function automatic logic [7:0] one_mask(input int pos);
        logic [7:0] m = '0;
        m[pos] = 1'b1;
        return m;
    endfunction

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            report();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "shd", shd, 1'b0);
        chk("R1", "shr", shr, 1'b0);
        chk("R1", "strobe_err", strobe_err, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "shd", shd, 1'b0);
        chk("R1", "shr", shr, 1'b0);
        chk("R1", "strobe_err", strobe_err, 1'b0);

        // Table walk: R2, R3, R4, R5, R6
        for (int v = 0; v < 12; v++) begin
            logic [7:0] e = VEC[v];
            int hi = int'(e[1:0]);
            logic [7:0] m_shd, m_shr;
            string t_shd;
            shd_from_strobe = e[7];
            cds_mode        = e[6];
            shd_width       = e[5:4];
            shr_delay       = e[3:2];
            m_shd = e[7] ? from_mask(8 - hi) : from_mask(7 - int'(e[5:4]));
            m_shr = e[6] ? one_mask(int'(e[3:2]) + 1) : 8'h00;
            t_shd = e[7] ? "R4" : ((hi != 1) ? "R3" : "R2");
            for (int p = 0; p < 3; p++)
                pixel(8 - hi, 7, p != 0, m_shd, m_shr, 8'h00,
                      t_shd, e[6] ? "R5" : "R6", "R8");
        end

        // R9 and R8: overlong strobe while locked with widest SHD
        shd_from_strobe = 1'b0;
        cds_mode        = 1'b1;
        shd_width       = 2'd3;
        shr_delay       = 2'd0;
        pixel(6, 7, 1'b0, 8'h00, 8'h00, 8'h00, "R9", "R9", "R8");
        pixel(6, 7, 1'b1, from_mask(4), one_mask(1), 8'h00, "R2", "R5", "R8");
        // high for edges 3..7: SHD up at 4,5, cut at 6; error after edge 6
        pixel(3, 7, 1'b1, 8'h30, one_mask(1), one_mask(6), "R9", "R5", "R8");
        // relock from the fall at edge 0
        pixel(6, 7, 1'b1, from_mask(4), one_mask(1), 8'h00, "R9", "R9", "R8");

        // R7: power-down holds outputs low, even in strobe mode
        pwr_on          = 1'b0;
        shd_from_strobe = 1'b1;
        pixel(6, 7, 1'b1, 8'h00, 8'h00, 8'h00, "R7", "R7", "R7");
        pixel(6, 7, 1'b1, 8'h00, 8'h00, 8'h00, "R7", "R7", "R7");
        // power back, clock-built SHD: first pixel has no fall yet
        pwr_on          = 1'b1;
        shd_from_strobe = 1'b0;
        shd_width       = 2'd0;
        shr_delay       = 2'd2;
        pixel(6, 7, 1'b1, 8'h00, 8'h00, 8'h00, "R7", "R7", "R7");
        pixel(6, 7, 1'b1, from_mask(7), one_mask(3), 8'h00, "R7", "R7", "R7");

        strobe = 1'b0;
        done = 1'b1;
        report();
    end

endmodule